// File: doc/BRIEF.md
# Power-Mode Peripheral Clock Gating Controller

This block decides which clocks run while the processor is active, napping or in its deepest low-power state. Three gate registers give the set of peripheral clocks that should run in each mode. A fixed capability mask, set by parameter, limits which bits of those registers can ever be set. A control register holds the auto-gating flag, the deep-sleep source choice and the run-time clock configuration: PLL on or off, source and divider field.

A one-cycle wait-for-interrupt strobe moves the controller out of Run. The deep-sleep request bit chooses light Sleep or Deep-Sleep. In both sleep modes the core clock enable drops. An interrupt-pending level brings the controller back. On entry to Deep-Sleep the controller snapshots the clock setup. It then forces the PLL down, moves to the chosen deep-sleep oscillator, and overrides the divider if the PLL had been running. On exit it first reapplies the snapshot and waits a fixed settling time, counted in cycles. Only then does it reopen the core and the run-mode peripheral clocks. The oscillators and PLL are outside the block and are driven through select, power-down and divider outputs.

Top module: `clkgate_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the controller is in Run with the state below. All three gate registers and the control register are zero. `core_clk_en`=1, `periph_clk_en`=0, `pll_pwr_down`=1, `osc_sel`=0, `main_osc_pwr_down`=0, `div_override`=0, `sys_div`=1.
- R2: A write at address 0 (Run gate), 1 (Sleep gate) or 2 (Deep gate) stores `reg_wdata & CAP_MASK`, effective from the next cycle. Address 3 reads `CAP_MASK`, and writes to it are ignored. Address 4 is control: bit0 auto-gate, bit1 deep-sleep internal oscillator, bit2 PLL enable, bit3 run source (0 main, 1 internal), bits 7:4 divider field. Other addresses read 0. No `periph_clk_en` bit outside `CAP_MASK` is ever 1.
- R3: In Run, `core_clk_en`=1 and `periph_clk_en` equals the Run gate. `osc_sel` equals the run source, `pll_pwr_down` is the inverse of PLL enable, `sys_div` is the divider field plus 1, and `main_osc_pwr_down`=0 and `div_override`=0.
- R4: A `wfi_strobe` in Run with `deep_req`=0 enters Sleep from the next cycle, and `core_clk_en` is 0 there.
- R5: A `wfi_strobe` in Run with `deep_req`=1 enters Deep-Sleep from the next cycle, and `core_clk_en` is 0 there. The strobe has no effect outside Run.
- R6: In Sleep, `periph_clk_en` is the Sleep gate when auto-gate is 1 and the Run gate otherwise. The clock outputs are as in Run.
- R7: In Deep-Sleep and during the exit restore, `periph_clk_en` is the Deep gate when auto-gate is 1 and the Run gate otherwise.
- R8: In Deep-Sleep, `pll_pwr_down`=1. `osc_sel` and `main_osc_pwr_down` both equal the deep-sleep internal-oscillator bit captured at entry.
- R9: In Deep-Sleep, if the PLL was enabled at entry, `div_override`=1 and `sys_div` is 16 on the main oscillator or 64 on the internal one. Otherwise `div_override`=0 and `sys_div` is the captured divider field plus 1.
- R10: `irq_pending` in Sleep returns the controller to Run on the next cycle.
- R11: `irq_pending` in Deep-Sleep starts a restore phase of `READY_CYC` cycles, then Run. During restore, `core_clk_en`=0 and `div_override`=0, and the clock outputs follow the setup captured at entry, even if control was rewritten in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| wfi_strobe | input | 1 | Wait-for-interrupt pulse |
| deep_req | input | 1 | Selects Deep-Sleep on the next strobe |
| irq_pending | input | 1 | Enabled interrupt pending |
| core_clk_en | output | 1 | Core and memory clock enable |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enables |
| pll_pwr_down | output | 1 | PLL power-down |
| osc_sel | output | 1 | Oscillator select, 0 main, 1 internal |
| main_osc_pwr_down | output | 1 | Main oscillator power-down |
| div_override | output | 1 | Deep-sleep divider override active |
| sys_div | output | 7 | System divide ratio |

## Verification
Several properties are checked on every cycle by the assertions. No enable may escape the capability mask. Each strobe and interrupt must move the mode as intended. Deep-Sleep must never hand back straight to Run, and an override cycle is never followed by an open core clock. Only the bench's scenarios show the values themselves. These are the choice between gate registers under each auto-gate setting, the /16 against /64 override, and the use of the captured setup in the restore phase after control was rewritten. The bench checks them against a behavioural model on every cycle.

// File: rtl/clkgate_pkg.sv
// Package: shared types and constants of the clock gating controller.
// Assumes the control register layout is fixed at 8 bits.
package clkgate_pkg;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'd0,
        MODE_SLEEP   = 2'd1,
        MODE_DEEP    = 2'd2,
        MODE_RESTORE = 2'd3
    } mode_e;

    // Control register, packed so bit positions match the register map.
    typedef struct packed {
        logic [3:0] div;
        logic       run_src;
        logic       pll_en;
        logic       ds_int;
        logic       auto_gate;
    } ctrl_t;

    // Clock setup captured on Deep-Sleep entry.
    typedef struct packed {
        logic [3:0] div;
        logic       run_src;
        logic       pll_en;
        logic       ds_int;
    } snap_t;

    localparam int unsigned SYS_DIV_W   = 7;
    localparam int unsigned DS_DIV_MAIN = 16;
    localparam int unsigned DS_DIV_INT  = 64;

    localparam logic [2:0] A_RUN  = 3'd0;
    localparam logic [2:0] A_SLP  = 3'd1;
    localparam logic [2:0] A_DSL  = 3'd2;
    localparam logic [2:0] A_CAP  = 3'd3;
    localparam logic [2:0] A_CTRL = 3'd4;

endpackage

// File: rtl/clkgate_regs.sv
// Register file: three per-mode gate registers masked by a capability
// mask, the control register, and a combinational read port.
// Assumes DATA_W >= 8 and N_PERIPH <= DATA_W.
module clkgate_regs
    import clkgate_pkg::*;
#(
    parameter int unsigned N_PERIPH = 8,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 3,
    parameter logic [N_PERIPH-1:0] CAP_MASK = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [N_PERIPH-1:0] run_gate,
    output logic [N_PERIPH-1:0] slp_gate,
    output logic [N_PERIPH-1:0] dsl_gate,
    output ctrl_t               ctrl
);

    localparam int unsigned NGATE = 3;

    logic [N_PERIPH-1:0] gate_q [NGATE];
    logic [N_PERIPH-1:0] wmasked;

    assign wmasked = wdata[N_PERIPH-1:0] & CAP_MASK;

    // One masked register per mode, selected by address.
    for (genvar g = 0; g < NGATE; g++) begin : g_gate
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gate_q[g] <= '0;
            end else if (we && addr == ADDR_W'(g)) begin
                gate_q[g] <= wmasked;
            end
        end
    end

    assign run_gate = gate_q[0];
    assign slp_gate = gate_q[1];
    assign dsl_gate = gate_q[2];

    // Control register: auto-gate, deep-sleep source and run clock setup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (we && addr == ADDR_W'(A_CTRL)) begin
            ctrl <= ctrl_t'(wdata[7:0]);
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_RUN):  rdata[N_PERIPH-1:0] = gate_q[0];
            ADDR_W'(A_SLP):  rdata[N_PERIPH-1:0] = gate_q[1];
            ADDR_W'(A_DSL):  rdata[N_PERIPH-1:0] = gate_q[2];
            ADDR_W'(A_CAP):  rdata[N_PERIPH-1:0] = CAP_MASK;
            ADDR_W'(A_CTRL): rdata[7:0]          = ctrl;
            default:         rdata               = '0;
        endcase
    end

    // R2: a write to the capability address leaves every gate register alone.
    assert_cap_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(A_CAP)) |=>
            ($stable(gate_q[0]) && $stable(gate_q[1]) && $stable(gate_q[2])));

endmodule

// File: rtl/clkgate_mode_fsm.sv
// Mode sequencer: Run, Sleep, Deep-Sleep and the post-deep-sleep restore
// phase. Captures the clock setup on Deep-Sleep entry and times the
// settling wait with a counter. Assumes READY_CYC >= 1.
module clkgate_mode_fsm
    import clkgate_pkg::*;
#(
    parameter int unsigned READY_CYC = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wfi,
    input  logic  deep_req,
    input  logic  irq,
    input  snap_t live,
    output mode_e mode,
    output snap_t saved
);

    localparam int unsigned CNT_W = (READY_CYC < 2) ? 1 : $clog2(READY_CYC + 1);

    mode_e           mode_d;
    logic [CNT_W-1:0] cnt_q;

    // Next-mode decision.
    always_comb begin
        mode_d = mode;
        case (mode)
            MODE_RUN:     if (wfi) mode_d = deep_req ? MODE_DEEP : MODE_SLEEP;
            MODE_SLEEP:   if (irq) mode_d = MODE_RUN;
            MODE_DEEP:    if (irq) mode_d = MODE_RESTORE;
            MODE_RESTORE: if (cnt_q == '0) mode_d = MODE_RUN;
            default:      mode_d = MODE_RUN;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_RUN;
        else        mode <= mode_d;
    end

    // Snapshot of the clock setup on Deep-Sleep entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved <= '0;
        end else if (mode == MODE_RUN && wfi && deep_req) begin
            saved <= live;
        end
    end

    // Settling counter for the restore phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (mode == MODE_DEEP && irq) begin
            cnt_q <= CNT_W'(READY_CYC - 1);
        end else if (mode == MODE_RESTORE && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_sleep_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && wfi && !deep_req) |=> mode == MODE_SLEEP);

    assert_deep_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && wfi && deep_req) |=> mode == MODE_DEEP);

    assert_sleep_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP && irq) |=> mode == MODE_RUN);

    assert_no_direct_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DEEP) |=> mode != MODE_RUN);

endmodule

// File: rtl/clkgate_out_mux.sv
// Output selection: picks the gate register for the current mode and the
// auto-gate flag, and the oscillator, PLL and divider controls from either
// the live setup or the Deep-Sleep snapshot. Purely combinational.
module clkgate_out_mux
    import clkgate_pkg::*;
#(
    parameter int unsigned N_PERIPH = 8
) (
    input  mode_e                 mode,
    input  ctrl_t                 ctrl,
    input  snap_t                 saved,
    input  logic [N_PERIPH-1:0]   run_gate,
    input  logic [N_PERIPH-1:0]   slp_gate,
    input  logic [N_PERIPH-1:0]   dsl_gate,
    output logic                  core_clk_en,
    output logic [N_PERIPH-1:0]   periph_clk_en,
    output logic                  pll_pwr_down,
    output logic                  osc_sel,
    output logic                  main_osc_pwr_down,
    output logic                  div_override,
    output logic [SYS_DIV_W-1:0]  sys_div
);

    logic [SYS_DIV_W-1:0] live_div;
    logic [SYS_DIV_W-1:0] saved_div;
    logic [SYS_DIV_W-1:0] ovr_div;

    assign live_div  = SYS_DIV_W'(ctrl.div) + 1'b1;
    assign saved_div = SYS_DIV_W'(saved.div) + 1'b1;
    assign ovr_div   = saved.ds_int ? SYS_DIV_W'(DS_DIV_INT) : SYS_DIV_W'(DS_DIV_MAIN);

    // Peripheral enables by mode and auto-gate flag.
    always_comb begin
        case (mode)
            MODE_RUN:   periph_clk_en = run_gate;
            MODE_SLEEP: periph_clk_en = ctrl.auto_gate ? slp_gate : run_gate;
            default:    periph_clk_en = ctrl.auto_gate ? dsl_gate : run_gate;
        endcase
    end

    // Clock source, PLL and divider controls by mode.
    always_comb begin
        core_clk_en       = (mode == MODE_RUN);
        osc_sel           = ctrl.run_src;
        pll_pwr_down      = !ctrl.pll_en;
        main_osc_pwr_down = 1'b0;
        div_override      = 1'b0;
        sys_div           = live_div;
        case (mode)
            MODE_DEEP: begin
                osc_sel           = saved.ds_int;
                main_osc_pwr_down = saved.ds_int;
                pll_pwr_down      = 1'b1;
                div_override      = saved.pll_en;
                sys_div           = saved.pll_en ? ovr_div : saved_div;
            end
            MODE_RESTORE: begin
                osc_sel      = saved.run_src;
                pll_pwr_down = !saved.pll_en;
                sys_div      = saved_div;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/clkgate_ctrl.sv
// Top of the power-mode clock gating controller: register file, mode
// sequencer and output selection. Assumes a single clock domain and
// pulse-wide wfi_strobe.
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter int unsigned N_PERIPH  = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned READY_CYC = 4,
    parameter logic [N_PERIPH-1:0] CAP_MASK = 8'h7B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 wfi_strobe,
    input  logic                 deep_req,
    input  logic                 irq_pending,
    output logic                 core_clk_en,
    output logic [N_PERIPH-1:0]  periph_clk_en,
    output logic                 pll_pwr_down,
    output logic                 osc_sel,
    output logic                 main_osc_pwr_down,
    output logic                 div_override,
    output logic [6:0]           sys_div
);

    logic [N_PERIPH-1:0] run_gate;
    logic [N_PERIPH-1:0] slp_gate;
    logic [N_PERIPH-1:0] dsl_gate;
    ctrl_t               ctrl;
    snap_t               live;
    snap_t               saved;
    mode_e               mode;

    assign live = '{div: ctrl.div, run_src: ctrl.run_src,
                    pll_en: ctrl.pll_en, ds_int: ctrl.ds_int};

    clkgate_regs #(
        .N_PERIPH (N_PERIPH),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .CAP_MASK (CAP_MASK)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .run_gate (run_gate),
        .slp_gate (slp_gate),
        .dsl_gate (dsl_gate),
        .ctrl     (ctrl)
    );

    clkgate_mode_fsm #(
        .READY_CYC (READY_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wfi      (wfi_strobe),
        .deep_req (deep_req),
        .irq      (irq_pending),
        .live     (live),
        .mode     (mode),
        .saved    (saved)
    );

    clkgate_out_mux #(
        .N_PERIPH (N_PERIPH)
    ) u_mux (
        .mode              (mode),
        .ctrl              (ctrl),
        .saved             (saved),
        .run_gate          (run_gate),
        .slp_gate          (slp_gate),
        .dsl_gate          (dsl_gate),
        .core_clk_en       (core_clk_en),
        .periph_clk_en     (periph_clk_en),
        .pll_pwr_down      (pll_pwr_down),
        .osc_sel           (osc_sel),
        .main_osc_pwr_down (main_osc_pwr_down),
        .div_override      (div_override),
        .sys_div           (sys_div)
    );

    assert_periph_in_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_clk_en & ~CAP_MASK) == '0);

    assert_override_then_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        div_override |=> !core_clk_en);

endmodule

// File: tb/test_clkgate_ctrl.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with every output on each falling edge, plus directed checks.
module test_clkgate_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NP    = 8;
    localparam int READY = 4;
    localparam logic [7:0] CAP = 8'h7B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       wfi_strobe = 1'b0;
    logic       deep_req = 1'b0;
    logic       irq_pending = 1'b0;
    logic       core_clk_en;
    logic [7:0] periph_clk_en;
    logic       pll_pwr_down, osc_sel, main_osc_pwr_down, div_override;
    logic [6:0] sys_div;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    clkgate_ctrl #(.N_PERIPH(NP), .DATA_W(8), .ADDR_W(3),
                   .READY_CYC(READY), .CAP_MASK(CAP)) i_clkgate_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wfi_strobe(wfi_strobe),
        .deep_req(deep_req), .irq_pending(irq_pending), .core_clk_en(core_clk_en),
        .periph_clk_en(periph_clk_en), .pll_pwr_down(pll_pwr_down), .osc_sel(osc_sel),
        .main_osc_pwr_down(main_osc_pwr_down), .div_override(div_override),
        .sys_div(sys_div));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state (0 run, 1 sleep, 2 deep, 3 restore).
    int m_mode = 0, m_cnt = 0;
    logic [7:0] m_gate [3];
    int m_auto = 0, m_dsint = 0, m_pll = 0, m_src = 0, m_div = 0;
    int s_dsint = 0, s_pll = 0, s_src = 0, s_div = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0;
            for (int i = 0; i < 3; i++) m_gate[i] = '0;
            m_auto = 0; m_dsint = 0; m_pll = 0; m_src = 0; m_div = 0;
            s_dsint = 0; s_pll = 0; s_src = 0; s_div = 0;
        end else begin
            case (m_mode)
                0: if (wfi_strobe) begin
                       if (deep_req) begin
                           m_mode = 2; s_dsint = m_dsint; s_pll = m_pll;
                           s_src = m_src; s_div = m_div;
                       end else m_mode = 1;
                   end
                1: if (irq_pending) m_mode = 0;
                2: if (irq_pending) begin m_mode = 3; m_cnt = READY - 1; end
                default: if (m_cnt == 0) m_mode = 0; else m_cnt--;
            endcase
            if (reg_we) begin
                if (reg_addr < 3) m_gate[reg_addr] = reg_wdata & CAP;
                else if (reg_addr == 4) begin
                    m_auto = reg_wdata[0]; m_dsint = reg_wdata[1];
                    m_pll = reg_wdata[2]; m_src = reg_wdata[3]; m_div = reg_wdata[7:4];
                end
            end
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string t;
            int e_per, e_osc, e_mpd, e_pll, e_ovr, e_div;
            t = (m_mode == 0) ? "R3" : (m_mode == 1) ? "R6" : (m_mode == 2) ? "R8" : "R11";
            case (m_mode)
                0: e_per = m_gate[0];
                1: e_per = m_auto ? m_gate[1] : m_gate[0];
                default: e_per = m_auto ? m_gate[2] : m_gate[0];
            endcase
            e_osc = (m_mode == 2) ? s_dsint : (m_mode == 3) ? s_src : m_src;
            e_mpd = (m_mode == 2) ? s_dsint : 0;
            e_pll = (m_mode == 2) ? 1 : (m_mode == 3) ? !s_pll : !m_pll;
            e_ovr = (m_mode == 2) ? s_pll : 0;
            if (m_mode == 2) e_div = s_pll ? (s_dsint ? 64 : 16) : s_div + 1;
            else if (m_mode == 3) e_div = s_div + 1;
            else e_div = m_div + 1;
            chk((m_mode == 1) ? "R4 core" : (m_mode == 2) ? "R5 core" : {t, " core"},
                int'(core_clk_en), int'(m_mode == 0));
            chk((m_mode >= 2) ? "R7 periph" : {t, " periph"}, int'(periph_clk_en), e_per);
            chk({t, " osc_sel"}, int'(osc_sel), e_osc);
            chk({t, " main_osc_pd"}, int'(main_osc_pwr_down), e_mpd);
            chk({t, " pll_pd"}, int'(pll_pwr_down), e_pll);
            chk((m_mode == 2) ? "R9 override" : {t, " override"}, int'(div_override), e_ovr);
            chk((m_mode == 2) ? "R9 sys_div" : {t, " sys_div"}, int'(sys_div), e_div);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input int exp, input string tag);
        @(negedge clk); reg_addr = a; #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic wfi(input logic deep);
        @(negedge clk); deep_req = deep; wfi_strobe = 1'b1;
        @(negedge clk); wfi_strobe = 1'b0; deep_req = 1'b0;
    endtask

    task automatic irq();
        @(negedge clk); irq_pending = 1'b1;
        @(negedge clk); irq_pending = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        #1;
        chk("R1 core", int'(core_clk_en), 1);
        chk("R1 periph", int'(periph_clk_en), 0);
        chk("R1 pll_pd", int'(pll_pwr_down), 1);
        chk("R1 sys_div", int'(sys_div), 1);
        chk("R1 osc", int'(osc_sel), 0);
        rd(3'd4, 0, "R1 ctrl");
        // R2: masked writes and readback
        wr(3'd0, 8'hFF); rd(3'd0, 8'h7B, "R2 run gate mask");
        wr(3'd1, 8'h0F); rd(3'd1, 8'h0B, "R2 sleep gate mask");
        wr(3'd2, 8'hF4); rd(3'd2, 8'h70, "R2 deep gate mask");
        wr(3'd3, 8'h00); rd(3'd3, 8'h7B, "R2 cap read-only");
        rd(3'd0, 8'h7B, "R2 cap write no effect");
        rd(3'd6, 0, "R2 unmapped");
        wr(3'd4, 8'h34); rd(3'd4, 8'h34, "R2 ctrl");  // div 3, pll on, main
        // R4/R6/R10: sleep with auto off, then wake
        wfi(1'b0); #1; chk("R4 sleep core off", int'(core_clk_en), 0);
        wfi(1'b1); // ignored outside Run (R5)
        idle(2); irq(); #1; chk("R10 woke to run", int'(core_clk_en), 1);
        // R6: sleep with auto on
        wr(3'd4, 8'h35); wfi(1'b0); #1;
        chk("R6 sleep gate", int'(periph_clk_en), 8'h0B);
        idle(2); irq();
        // R5/R7/R9/R11: deep, PLL on, main osc -> /16, ctrl rewritten in deep
        wfi(1'b1); #1;
        chk("R5 deep core off", int'(core_clk_en), 0);
        chk("R9 div16", int'(sys_div), 16);
        wr(3'd4, 8'h71);
        irq(); #1;
        chk("R11 restore saved div", int'(sys_div), 4);
        chk("R11 restore core off", int'(core_clk_en), 0);
        idle(READY + 1);
        chk("R11 back in run", int'(core_clk_en), 1);
        chk("R11 new ctrl live", int'(sys_div), 8);
        // R8/R9: internal osc, PLL on -> /64
        wr(3'd4, 8'h27); wfi(1'b1); #1;
        chk("R8 internal osc", int'(osc_sel), 1);
        chk("R8 main osc down", int'(main_osc_pwr_down), 1);
        chk("R9 div64", int'(sys_div), 64);
        irq(); idle(READY + 2);
        // R9: PLL off -> no override; R7 auto off uses run gate
        wr(3'd4, 8'h50); wfi(1'b1); #1;
        chk("R9 no override", int'(div_override), 0);
        chk("R9 saved div", int'(sys_div), 6);
        chk("R7 run gate in deep", int'(periph_clk_en), 8'h7B);
        irq(); idle(READY + 2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule